// File: doc/BRIEF.md
# Priority Memory-Grant Flow Controller

This block keeps a running count of the shared packet-memory locations that are in use. From that count it produces four grant signals, one for each packet priority, that tell upstream adapters whether they may keep sending. Each priority has its own programmable limit. A grant is withdrawn when occupancy rises above its limit and is restored when occupancy falls below it. Grants are re-evaluated only on a logical-unit tick, so the block adds exactly one LU to the grant loop delay.

Two capacity settings are supported, chosen by a mode input: 256 locations or 512 locations. In both settings 32 locations are held back for the input side and are never counted as usable. A combinational helper computes the suggested limit for priority 0 from the grant loop delay and the number of control-packet locations. A sticky flag reports any programming in which the limits do not fall from priority 0 down to priority 3.

Top module: `memGrantCtl`

## Requirements
- R1: After reset `allocCount` is 0, all four bits of `memGrant` are 1 and `cfgErr` is 0.
- R2: An allocate strobe alone adds 1 to `allocCount`. A release strobe alone subtracts 1. When both strobes arrive in the same cycle the count is unchanged.
- R3: `allocCount` never goes below 0. It never rises above the usable capacity, which is the capacity minus 32.
- R4: A write with `cfgWrEn`=1 stores `cfgWrData` into the limit of the priority given by `cfgAddr` (0 to 3). Bit p of `memGrant` belongs to priority p.
- R5: `memGrant` changes only on the clock edge that follows a cycle with `luTick`=1. At every other edge it holds its value.
- R6: At a tick edge, grant p is cleared if the count is above limit p and set if the count is below limit p. If the count equals limit p, grant p keeps its previous value.
- R7: `cfgErr` becomes 1 on the edge after any cycle in which limit p is lower than limit p+1. Once set, it stays 1 until reset.
- R8: `recThresh0` equals capacity − 16 × `grantDelayLu` − `ctrlPktLocs` − 32. If that result would be negative, the output is 0.
- R9: With `speedExp`=0 the capacity is 256, giving 224 usable locations. With `speedExp`=1 the capacity is 512, giving 480 usable locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocStb | input | 1 | One location allocated this cycle |
| releaseStb | input | 1 | One location released this cycle |
| speedExp | input | 1 | Capacity mode: 0 = 256 locations, 1 = 512 locations |
| luTick | input | 1 | Logical-unit tick; grants are sampled on the next edge |
| cfgWrEn | input | 1 | Limit write strobe |
| cfgAddr | input | 2 | Priority whose limit is written |
| cfgWrData | input | CNT_W | Limit value |
| grantDelayLu | input | DLY_W | Grant loop delay in LUs, input to the helper |
| ctrlPktLocs | input | CPL_W | Control-packet locations, input to the helper |
| memGrant | output | 4 | Per-priority memory grants |
| cfgErr | output | 1 | Sticky flag for limits out of order |
| allocCount | output | CNT_W | Allocated location count |
| recThresh0 | output | CNT_W | Suggested priority-0 limit |

## Verification
Two things can fall in the same cycle: a counter update and a grant evaluation. A tick can coincide with an allocate or a release, and the grant must be judged on the count as it stood before that edge. The bench sends strobe streams while ticks arrive on a fixed stride, so ticks land on both rising and falling counts. It also drives ticks while the count passes exactly through each limit. On every clock a behavioural model, which uses the old count for grants and the old limits for the order check, is compared against the outputs. A limit write that lands in the same cycle as a tick is covered the same way.

// File: rtl/memGrantPkg.sv
package memGrantPkg;
  localparam int NUM_PRIO = 4;
  localparam int ADDR_W = $clog2(NUM_PRIO);
  localparam int BASE_CAP = 256;
  localparam int RESERVED_LOCS = 32;
  localparam int LOCS_PER_LU = 16;

  typedef struct packed {
    logic inc;
    logic dec;
    logic sample;
    logic [NUM_PRIO-1:0] wrEn;
  } dpCmd_t;
endpackage

// File: rtl/memGrantCtrl.sv
module memGrantCtrl
  import memGrantPkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              allocStb,
  input  logic              releaseStb,
  input  logic              speedExp,
  input  logic              luTick,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  allocCount,
  output dpCmd_t            cmd
);
  localparam logic [CNT_W-1:0] USABLE_LO = CNT_W'(BASE_CAP - RESERVED_LOCS);
  localparam logic [CNT_W-1:0] USABLE_HI = CNT_W'(2 * BASE_CAP - RESERVED_LOCS);

  logic [CNT_W-1:0] usable;
  assign usable = speedExp ? USABLE_HI : USABLE_LO;

  always_comb begin
    cmd.inc    = allocStb && !releaseStb && (allocCount < usable);
    cmd.dec    = releaseStb && !allocStb && (allocCount != '0);
    cmd.sample = luTick;
    for (int p = 0; p < NUM_PRIO; p++) begin
      cmd.wrEn[p] = cfgWrEn && (cfgAddr == ADDR_W'(p));
    end
  end
endmodule

// File: rtl/memGrantDp.sv
module memGrantDp
  import memGrantPkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  dpCmd_t                           cmd,
  input  logic [CNT_W-1:0]                 cfgWrData,
  output logic [CNT_W-1:0]                 allocCount,
  output logic [NUM_PRIO-1:0][CNT_W-1:0]   thrVec,
  output logic [NUM_PRIO-1:0]              memGrant,
  output logic                             cfgErr
);
  logic orderBad;

  always_ff @(posedge clk) begin
    if (!rstN) allocCount <= '0;
    else if (cmd.inc) allocCount <= allocCount + 1'b1;
    else if (cmd.dec) allocCount <= allocCount - 1'b1;
  end

  for (genvar p = 0; p < NUM_PRIO; p++) begin : gPrio
    always_ff @(posedge clk) begin
      if (!rstN) thrVec[p] <= '0;
      else if (cmd.wrEn[p]) thrVec[p] <= cfgWrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) memGrant[p] <= 1'b1;
      else if (cmd.sample) begin
        if (allocCount > thrVec[p]) memGrant[p] <= 1'b0;
        else if (allocCount < thrVec[p]) memGrant[p] <= 1'b1;
      end
    end
  end

  always_comb begin
    orderBad = 1'b0;
    for (int p = 0; p < NUM_PRIO - 1; p++) begin
      if (thrVec[p] < thrVec[p+1]) orderBad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgErr <= 1'b0;
    else if (orderBad) cfgErr <= 1'b1;
  end
endmodule

// File: rtl/memGrantRec.sv
module memGrantRec
  import memGrantPkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DLY_W = 5,
  parameter int CPL_W = 8
) (
  input  logic             speedExp,
  input  logic [DLY_W-1:0] grantDelayLu,
  input  logic [CPL_W-1:0] ctrlPktLocs,
  output logic [CNT_W-1:0] recThresh0
);
  localparam int RW = CNT_W + DLY_W + CPL_W;

  logic [RW-1:0] cap;
  logic [RW-1:0] deduct;

  always_comb begin
    cap    = speedExp ? RW'(2 * BASE_CAP) : RW'(BASE_CAP);
    deduct = RW'(grantDelayLu) * RW'(LOCS_PER_LU) + RW'(ctrlPktLocs) + RW'(RESERVED_LOCS);
    recThresh0 = (deduct >= cap) ? '0 : CNT_W'(cap - deduct);
  end
endmodule

// File: rtl/memGrantCtl.sv
module memGrantCtl
  import memGrantPkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DLY_W = 5,
  parameter int CPL_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                allocStb,
  input  logic                releaseStb,
  input  logic                speedExp,
  input  logic                luTick,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [CNT_W-1:0]    cfgWrData,
  input  logic [DLY_W-1:0]    grantDelayLu,
  input  logic [CPL_W-1:0]    ctrlPktLocs,
  output logic [NUM_PRIO-1:0] memGrant,
  output logic                cfgErr,
  output logic [CNT_W-1:0]    allocCount,
  output logic [CNT_W-1:0]    recThresh0
);
  dpCmd_t cmd;
  logic [NUM_PRIO-1:0][CNT_W-1:0] thrVec;

  memGrantCtrl #(.CNT_W(CNT_W)) uCtrl (
    .allocStb(allocStb), .releaseStb(releaseStb), .speedExp(speedExp),
    .luTick(luTick), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .allocCount(allocCount), .cmd(cmd)
  );

  memGrantDp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cfgWrData(cfgWrData),
    .allocCount(allocCount), .thrVec(thrVec), .memGrant(memGrant), .cfgErr(cfgErr)
  );

  memGrantRec #(.CNT_W(CNT_W), .DLY_W(DLY_W), .CPL_W(CPL_W)) uRec (
    .speedExp(speedExp), .grantDelayLu(grantDelayLu),
    .ctrlPktLocs(ctrlPktLocs), .recThresh0(recThresh0)
  );
endmodule

// File: rtl/memGrantChk.sv
module memGrantChk
  import memGrantPkg::*;
#(
  parameter int CNT_W = 10
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           allocStb,
  input logic                           releaseStb,
  input logic                           speedExp,
  input logic                           luTick,
  input logic [CNT_W-1:0]               allocCount,
  input logic [NUM_PRIO-1:0]            memGrant,
  input logic                           cfgErr,
  input logic [NUM_PRIO-1:0][CNT_W-1:0] thrVec
);
  logic [CNT_W-1:0] usableLim;
  assign usableLim = speedExp ? CNT_W'(2 * BASE_CAP - RESERVED_LOCS)
                              : CNT_W'(BASE_CAP - RESERVED_LOCS);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !luTick |=> $stable(memGrant));

  assert_both_R2: assert property (@(posedge clk) disable iff (!rstN)
    allocStb && releaseStb |=> $stable(allocCount));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    allocStb && !releaseStb && allocCount >= usableLim |=> $stable(allocCount));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    releaseStb && !allocStb && allocCount == '0 |=> allocCount == '0);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

  for (genvar p = 0; p < NUM_PRIO; p++) begin : gChk
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
      luTick && allocCount > thrVec[p] |=> !memGrant[p]);
    assert_set_R6: assert property (@(posedge clk) disable iff (!rstN)
      luTick && allocCount < thrVec[p] |=> memGrant[p]);
  end
endmodule

bind memGrantCtl memGrantChk #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .allocStb(allocStb), .releaseStb(releaseStb),
  .speedExp(speedExp), .luTick(luTick), .allocCount(allocCount),
  .memGrant(memGrant), .cfgErr(cfgErr), .thrVec(thrVec)
);

// File: tb/memGrantCtl_test.sv
module memGrantCtl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocStb = 0, releaseStb = 0, speedExp = 0, luTick = 0, cfgWrEn = 0;
  logic [1:0] cfgAddr = 0;
  logic [9:0] cfgWrData = 0;
  logic [4:0] grantDelayLu = 0;
  logic [7:0] ctrlPktLocs = 0;
  logic [3:0] memGrant;
  logic cfgErr;
  logic [9:0] allocCount, recThresh0;

  int checks = 0, failures = 0;
  int mCnt = 0;
  int mThr[4] = '{0, 0, 0, 0};
  bit mG[4] = '{1, 1, 1, 1};
  bit mErr = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  memGrantCtl uut (
    .clk(clk), .rstN(rstN), .allocStb(allocStb), .releaseStb(releaseStb),
    .speedExp(speedExp), .luTick(luTick), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .grantDelayLu(grantDelayLu), .ctrlPktLocs(ctrlPktLocs),
    .memGrant(memGrant), .cfgErr(cfgErr), .allocCount(allocCount), .recThresh0(recThresh0)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int expG = 0;
    int rec;
    for (int p = 0; p < 4; p++) if (mG[p]) expG |= (1 << p);
    rec = (speedExp ? 512 : 256) - 16 * int'(grantDelayLu) - int'(ctrlPktLocs) - 32;
    if (rec < 0) rec = 0;
    check(curReq, "allocCount", int'(allocCount), mCnt);
    check("R5/R6", "memGrant", int'(memGrant), expG);
    check("R7", "cfgErr", int'(cfgErr), int'(mErr));
    check("R8", "recThresh0", int'(recThresh0), rec);
  endtask

  task automatic cyc();
    int usable;
    int oc;
    @(posedge clk);
    if (!rstN) begin
      mCnt = 0; mErr = 0;
      for (int p = 0; p < 4; p++) begin mThr[p] = 0; mG[p] = 1; end
    end else begin
      usable = speedExp ? 480 : 224;
      oc = mCnt;
      if (luTick)
        for (int p = 0; p < 4; p++) begin
          if (oc > mThr[p]) mG[p] = 0;
          else if (oc < mThr[p]) mG[p] = 1;
        end
      for (int p = 0; p < 3; p++) if (mThr[p] < mThr[p+1]) mErr = 1;
      if (allocStb && !releaseStb && oc < usable) mCnt = oc + 1;
      else if (releaseStb && !allocStb && oc > 0) mCnt = oc - 1;
      if (cfgWrEn) mThr[cfgAddr] = int'(cfgWrData);
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic setThr(int p, int v);
    cfgWrEn = 1; cfgAddr = 2'(p); cfgWrData = 10'(v);
    cyc();
    cfgWrEn = 0;
  endtask

  task automatic run(int n, bit a, bit r, int stride);
    for (int i = 0; i < n; i++) begin
      allocStb = a; releaseStb = r;
      luTick = ((i % stride) == 0);
      cyc();
    end
    allocStb = 0; releaseStb = 0; luTick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    check("R1", "allocCount", int'(allocCount), 0);
    check("R1", "memGrant", int'(memGrant), 15);
    check("R1", "cfgErr", int'(cfgErr), 0);

    curReq = "R4";
    setThr(0, 200); setThr(1, 150); setThr(2, 100); setThr(3, 50);

    curReq = "R2";
    run(60, 1, 0, 4);
    run(6, 1, 1, 2);
    run(10, 0, 1, 3);
    run(55, 1, 0, 5);

    curReq = "R6";
    run(3, 0, 1, 1);
    run(3, 1, 0, 1);
    run(40, 1, 0, 1);
    run(20, 0, 1, 1);

    curReq = "R3";
    run(250, 1, 0, 8);
    run(3, 1, 0, 1);
    run(240, 0, 1, 7);
    run(3, 0, 1, 1);

    curReq = "R9";
    speedExp = 1;
    setThr(0, 400); setThr(1, 300); setThr(2, 200); setThr(3, 100);
    run(500, 1, 0, 6);
    run(490, 0, 1, 9);

    curReq = "R7";
    luTick = 1; setThr(3, 250); luTick = 0;
    run(3, 0, 0, 1);
    setThr(3, 10);
    run(3, 0, 0, 1);

    curReq = "R8";
    for (int s = 0; s < 2; s++) begin
      speedExp = s[0];
      for (int d = 0; d < 32; d += 5) begin
        for (int c = 0; c < 256; c += 60) begin
          grantDelayLu = 5'(d); ctrlPktLocs = 8'(c);
          cyc();
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule